// File: doc/BRIEF.md
# Extended Integer Arithmetic Logic Unit

This block is the combinational integer execution stage of a single-cycle 32-bit datapath. Each evaluation takes two operands, a 5-bit immediate shift count and a 6-bit operation code. It returns a 32-bit result and a flag that is high when that result is zero. No clock or state is involved, so the result follows the inputs within the same cycle.

The operation code is shared between a bitwise unit, a single adder and a barrel shifter:

- Bit 4 of the code complements operand B before it enters the bitwise unit or the adder. The inverted-operand logic forms therefore come from the same gates as the plain forms.
- Subtraction and signed compare use the same adder as addition.
- Bit 5 of the code chooses whether the shift count comes from the immediate field or from operand A.

Any code outside the defined set gives a zero result.

Top module: `xalu_core`

## Requirements
- R1: Codes 0x00, 0x01, 0x05 and 0x06 return A AND B, A OR B, A XOR B and NOT(A OR B).
- R2: Codes 0x10, 0x11, 0x15 and 0x16 return A AND ~B, A OR ~B, A XOR ~B and NOT(A OR ~B), where ~B is the bitwise complement of operand B.
- R3: Code 0x02 returns A+B modulo 2^32.
- R4: Code 0x12 returns A−B modulo 2^32.
- R5: Code 0x13 returns 1 when A is less than B as two's-complement numbers, and 0 otherwise. The answer is correct even when A−B overflows.
- R6: Codes 0x04, 0x07 and 0x08 shift operand B by the immediate count. They are logical left, logical right and arithmetic right, in that order. The arithmetic right shift copies B[31] into the vacated bits.
- R7: Codes 0x24, 0x27 and 0x28 perform the same three shifts on B. The count is A[4:0], and A[31:5] has no effect on the result.
- R8: Every code not listed in R1 to R7 returns a result of 0. This includes 0x03 and 0x14.
- R9: The zero output is 1 exactly when the 32-bit result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Operand A; its low 5 bits are the count for variable shifts |
| opb_i | input | 32 | Operand B; the operand that gets shifted |
| shamt_i | input | 5 | Immediate shift count |
| ctrl_i | input | 6 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The hardest case to reach is a signed compare where A−B overflows. Here the raw sign of the difference gives the wrong answer, and random operands rarely land there. The stimulus drives it directly with the most negative number against positive values, and the most positive number against negative values. A second hard case is a variable shift where A[31:5] is non-zero. That stimulus sets the upper bits of A to ones while holding the low five bits fixed, and expects the same result as with those upper bits cleared.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  localparam int unsigned CODE_W = 6;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_BITOP = 3'd1,
    CLS_ARITH = 3'd2,
    CLS_CMP   = 3'd3,
    CLS_SHIFT = 3'd4
  } op_class_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_NONE  = 2'd3
  } shift_kind_e;

  // Map an operation code onto the execution path that serves it.
  function automatic op_class_e f_classify(input logic [CODE_W-1:0] c);
    op_class_e k;
    case (c)
      6'h00, 6'h01, 6'h05, 6'h06,
      6'h10, 6'h11, 6'h15, 6'h16: k = CLS_BITOP;
      6'h02, 6'h12:               k = CLS_ARITH;
      6'h13:                      k = CLS_CMP;
      6'h04, 6'h07, 6'h08,
      6'h24, 6'h27, 6'h28:        k = CLS_SHIFT;
      default:                    k = CLS_NONE;
    endcase
    return k;
  endfunction

  // Low three bits pick the shift direction and fill.
  function automatic shift_kind_e f_shift_kind(input logic [2:0] lo);
    shift_kind_e k;
    case (lo)
      3'b100:  k = SH_LEFT;
      3'b111:  k = SH_RLOG;
      3'b000:  k = SH_RARI;
      default: k = SH_NONE;
    endcase
    return k;
  endfunction

  // Signed less-than from a difference and its overflow indication.
  function automatic logic f_lt_from_diff(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

endpackage

// File: rtl/xalu_bitop.sv
module xalu_bitop #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (sel_i)
      3'b000:  y_o = a_i & b_i;
      3'b001:  y_o = a_i | b_i;
      3'b101:  y_o = a_i ^ b_i;
      3'b110:  y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/xalu_adder.sv
module xalu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] cin_ext;
  assign cin_ext = {{(W-1){1'b0}}, cin_i};
  assign sum_o   = a_i + b_i + cin_ext;
  assign ovf_o   = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/xalu_shifter.sv
module xalu_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic [W-1:0] stg [0:SW];
  logic         fill;

  // A left shift is done as a right shift of the bit-reversed word.
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rev
      assign pre[gi]  = left_i ? d_i[W-1-gi]  : d_i[gi];
      assign q_o[gi]  = left_i ? post[W-1-gi] : post[gi];
    end
  endgenerate

  assign fill   = arith_i & ~left_i & d_i[W-1];
  assign stg[0] = pre;

  genvar gs;
  generate
    for (gs = 0; gs < SW; gs++) begin : g_stage
      localparam int unsigned STEP = 1 << gs;
      assign stg[gs+1] = amt_i[gs] ? {{STEP{fill}}, stg[gs][W-1:STEP]} : stg[gs];
    end
  endgenerate

  assign post = stg[SW];
endmodule

// File: rtl/xalu_core.sv
module xalu_core
  import xalu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [SW-1:0]     shamt_i,
  input  logic [CODE_W-1:0] ctrl_i,
  output logic [W-1:0]      result_o,
  output logic              zero_o
);
  op_class_e   op_cls;
  shift_kind_e sh_kind;
  logic        b_invert;
  logic        sh_var;
  logic [W-1:0]  b_eff;
  logic [W-1:0]  bitop_y;
  logic [W-1:0]  sum_w;
  logic          ovf_w;
  logic          lt_w;
  logic [SW-1:0] sh_amt;
  logic [W-1:0]  shift_y;

  assign op_cls   = f_classify(ctrl_i);
  assign sh_kind  = f_shift_kind(ctrl_i[2:0]);
  assign b_invert = ctrl_i[4];
  assign sh_var   = ctrl_i[5];
  assign b_eff    = b_invert ? ~opb_i : opb_i;

  xalu_bitop #(.W(W)) u_bitop (
    .a_i(opa_i), .b_i(b_eff), .sel_i(ctrl_i[2:0]), .y_o(bitop_y)
  );

  xalu_adder #(.W(W)) u_adder (
    .a_i(opa_i), .b_i(b_eff), .cin_i(b_invert), .sum_o(sum_w), .ovf_o(ovf_w)
  );

  assign lt_w   = f_lt_from_diff(sum_w[W-1], ovf_w);
  assign sh_amt = sh_var ? opa_i[SW-1:0] : shamt_i;

  xalu_shifter #(.W(W), .SW(SW)) u_shift (
    .d_i(opb_i), .amt_i(sh_amt),
    .left_i(sh_kind == SH_LEFT), .arith_i(sh_kind == SH_RARI),
    .q_o(shift_y)
  );

  always_comb begin
    case (op_cls)
      CLS_BITOP: result_o = bitop_y;
      CLS_ARITH: result_o = sum_w;
      CLS_CMP:   result_o = {{(W-1){1'b0}}, lt_w};
      CLS_SHIFT: result_o = shift_y;
      default:   result_o = '0;
    endcase
  end

  assign zero_o = (result_o == '0);
endmodule

// File: rtl/xalu_core_chk.sv
module xalu_core_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input logic [W-1:0]  opa_i,
  input logic [W-1:0]  opb_i,
  input logic [5:0]    ctrl_i,
  input logic [W-1:0]  result_o,
  input logic          zero_o,
  input logic [W-1:0]  sum_w,
  input logic          ovf_w
);
  always_comb begin
    if (zero_o)
      AST_ZERO_MEANS_EMPTY: assert (result_o == '0);                        // R9
    if (ctrl_i == 6'h03 || ctrl_i == 6'h14 || ctrl_i == 6'h3f)
      AST_UNUSED_CLEARS: assert (result_o == '0 && zero_o);                 // R8
    if (ctrl_i == 6'h13)
      AST_CMP_IS_BOOLEAN: assert (result_o[W-1:1] == '0);                   // R5
    if (ctrl_i == 6'h12)
      AST_SUB_UNDOES: assert (result_o + opb_i == opa_i);                   // R4
    if (ctrl_i == 6'h02)
      AST_ADD_PATH: assert (result_o == sum_w);                             // R3
    if ((ctrl_i == 6'h24 || ctrl_i == 6'h27 || ctrl_i == 6'h28) && opa_i[SW-1:0] == '0)
      AST_VSHIFT_IDENTITY: assert (result_o == opb_i);                      // R7
    if (ctrl_i == 6'h13 && ovf_w)
      AST_CMP_OVF_SIGN: assert (result_o[0] == opa_i[W-1]);                 // R5
  end
endmodule

bind xalu_core xalu_core_chk #(.W(W), .SW(SW)) u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .ctrl_i(ctrl_i),
  .result_o(result_o), .zero_o(zero_o), .sum_w(sum_w), .ovf_w(ovf_w)
);

// File: tb/tb_xalu_core.sv
module tb_xalu_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a, b, y;
  logic [4:0]  sh;
  logic [5:0]  c;
  logic        z;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  xalu_core dut (.opa_i(a), .opb_i(b), .shamt_i(sh), .ctrl_i(c),
                 .result_o(y), .zero_o(z));

  function automatic logic [31:0] model(input logic [5:0] op, input logic [31:0] x,
                                        input logic [31:0] w, input logic [4:0] s);
    logic [31:0] nw;
    nw = ~w;
    case (op)
      6'h00: return x & w;
      6'h01: return x | w;
      6'h05: return x ^ w;
      6'h06: return ~(x | w);
      6'h10: return x & nw;
      6'h11: return x | nw;
      6'h15: return x ^ nw;
      6'h16: return ~(x | nw);
      6'h02: return x + w;
      6'h12: return x - w;
      6'h13: return ($signed(x) < $signed(w)) ? 32'd1 : 32'd0;
      6'h04: return w << s;
      6'h07: return w >> s;
      6'h08: return $unsigned($signed(w) >>> s);
      6'h24: return w << x[4:0];
      6'h27: return w >> x[4:0];
      6'h28: return $unsigned($signed(w) >>> x[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic run(input string req, input logic [5:0] op, input logic [31:0] x,
                     input logic [31:0] w, input logic [4:0] s);
    logic [31:0] exp;
    @(negedge clk);
    a = x; b = w; c = op; sh = s;
    #1;
    exp = model(op, x, w, s);
    n_chk++;
    if (y !== exp || z !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL %s code=%h a=%h b=%h sh=%0d: got y=%h z=%b, want y=%h z=%b",
               req, op, x, w, s, y, z, exp, exp == 32'd0);
    end
  endtask

  task automatic t_reset_state();
    run("R1", 6'h00, 32'd0, 32'd0, 5'd0);
  endtask

  task automatic t_bitops();
    run("R1", 6'h00, 32'hF0F0_1234, 32'hFF00_FF00, 0);
    run("R1", 6'h01, 32'hF0F0_1234, 32'h0F00_0001, 0);
    run("R1", 6'h05, 32'hAAAA_5555, 32'hFFFF_0000, 0);
    run("R1", 6'h06, 32'h0000_FFFF, 32'hFFFF_0000, 0);
    for (int i = 0; i < 8; i++) begin
      lfsr = nxt(lfsr); run("R1", 6'h05, lfsr, ~lfsr ^ 32'h1, 0);
    end
  endtask

  task automatic t_inverted();
    run("R2", 6'h10, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 0);
    run("R2", 6'h11, 32'h0000_0000, 32'hFFFF_FFFE, 0);
    run("R2", 6'h15, 32'h1234_5678, 32'h1234_5678, 0);
    run("R2", 6'h16, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    run("R2", 6'h16, 32'h8000_0000, 32'h0000_0001, 0);
  endtask

  task automatic t_add_sub();
    run("R3", 6'h02, 32'hFFFF_FFFF, 32'h0000_0001, 0);
    run("R3", 6'h02, 32'h7FFF_FFFF, 32'h0000_0001, 0);
    run("R4", 6'h12, 32'h0000_0000, 32'h0000_0001, 0);
    run("R4", 6'h12, 32'h8000_0000, 32'h0000_0001, 0);
    for (int i = 0; i < 6; i++) begin
      lfsr = nxt(lfsr); run("R3", 6'h02, lfsr, {lfsr[15:0], lfsr[31:16]}, 0);
      run("R4", 6'h12, lfsr, lfsr ^ 32'h0F0F, 0);
    end
  endtask

  task automatic t_compare();
    run("R5", 6'h13, 32'h8000_0000, 32'h0000_0001, 0);
    run("R5", 6'h13, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
    run("R5", 6'h13, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    run("R5", 6'h13, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    run("R5", 6'h13, 32'h0000_0005, 32'h0000_0005, 0);
    run("R5", 6'h13, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_imm_shift();
    for (int s = 0; s < 32; s += 7) begin
      run("R6", 6'h04, 32'h0, 32'h8765_4321, s[4:0]);
      run("R6", 6'h07, 32'h0, 32'h8765_4321, s[4:0]);
      run("R6", 6'h08, 32'h0, 32'h8765_4321, s[4:0]);
    end
    run("R6", 6'h08, 32'h0, 32'h8000_0000, 5'd31);
  endtask

  task automatic t_var_shift();
    run("R7", 6'h24, 32'h0000_0004, 32'h0000_0003, 5'd9);
    run("R7", 6'h27, 32'hFFFF_FFE8, 32'hF000_0000, 5'd1);
    run("R7", 6'h28, 32'hFFFF_FFE8, 32'hF000_0000, 5'd0);
    run("R7", 6'h28, 32'hFFFF_FFFF, 32'h9000_0000, 5'd3);
    run("R7", 6'h24, 32'hFFFF_FFE0, 32'h1234_5678, 5'd7);
  endtask

  task automatic t_unused();
    for (int k = 0; k < 64; k++) begin
      lfsr = nxt(lfsr);
      if (model(k[5:0], 32'hFFFF_FFFF, 32'h5555_5555, 5'd3) == 32'd0 ||
          k == 3 || k == 20)
        run("R8", k[5:0], lfsr, lfsr ^ 32'h5A5A_5A5A, lfsr[4:0]);
    end
  endtask

  task automatic t_zero_flag();
    run("R9", 6'h02, 32'h0000_0001, 32'hFFFF_FFFF, 0);
    run("R9", 6'h12, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0);
    run("R9", 6'h04, 32'h0, 32'h0000_0002, 5'd31);
    run("R9", 6'h06, 32'h0, 32'h0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no completion, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    a = '0; b = '0; c = '0; sh = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_bitops();
    t_inverted();
    t_add_sub();
    t_compare();
    t_imm_shift();
    t_var_shift();
    t_unused();
    t_zero_flag();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule